// File: doc/BRIEF.md
# Programmable Bus Bit-Rate Tick Generator

This block turns a fast reference clock into a one-cycle enable pulse that paces a serial bus. Software sets the pace through a 13-bit divisor held in two byte-wide registers. The tick period equals a fixed prescale factor times that divisor, counted in reference cycles. A divisor of zero stops the generator. It also stops whenever neither the receive side nor the transmit side of the bus is switched on.

The divisor is split across two registers. The upper register carries the five most significant divisor bits and three mode flags. A write to the upper register is only held aside in a staging register. It becomes live, together with the lower byte, when the lower register is written. This gives software an atomic two-byte update. The counter reloads at the moment a new divisor goes live and at the moment the generator is switched back on, so the first period after either event is never cut short.

A third register holds three bus configuration flags, which the block drives straight out as levels: open-drain pin mode, bus-mode enable and parity select.

Top module: `bclk_rate_gen`

## Requirements
- R1: After reset, the upper rate register reads 0x00, the lower rate register reads 0x04, and the control register reads 0x00. The tick and all mode and configuration outputs are low.
- R2: While running, `tick` is high for exactly one cycle and repeats every PRESCALE × D cycles. D is the live 13-bit divisor: upper register bits 4..0 form D[12:8], and the lower register forms D[7:0].
- R3: When D is 0, no tick is produced.
- R4: When `rx_en` and `tx_en` are both low, no tick is produced. Either input alone is enough to run the generator.
- R5: A write to the upper register (select 0) does not change the value read back from it, the mode outputs, or the tick period.
- R6: A write to the lower register (select 1) makes the staged upper byte and the written lower byte live in the same cycle. Upper bits 7, 6 and 5 then drive `test_mode`, `sample_mode` and `reset_mode`.
- R7: In the control register (select 2), bit 6 drives `wired_or_mode`, bit 5 drives `bus_mode_en` and bit 0 drives `parity_odd`. All other bits read as zero.
- R8: After a lower-byte write, or after the generator turns on, the first tick comes PRESCALE × D cycles after the clock edge that sampled the write or the enable.
- R9: Select 3 reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 upper rate, 1 lower rate, 2 control, 3 none |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| rx_en | input | 1 | Receiver enable |
| tx_en | input | 1 | Transmitter enable |
| tick | output | 1 | One-cycle bit-rate pulse |
| wired_or_mode | output | 1 | Open-drain pin mode flag |
| bus_mode_en | output | 1 | Bus mode enable flag |
| parity_odd | output | 1 | Parity select flag |
| test_mode | output | 1 | Live upper-register bit 7 |
| sample_mode | output | 1 | Live upper-register bit 6 |
| reset_mode | output | 1 | Live upper-register bit 5 |

## Verification
The bench writes a lone upper byte and confirms that both the readback and the tick period stay at their old values. A design that applied the upper byte straight away would show the new period early. The first tick after a commit and after switching on is timed to the exact cycle, so a counter that kept its stale count, or reloaded one cycle late, is caught. A zero divisor, the all-disabled state and the full 8191 divisor probe the stop condition and the top of the counter width. Writes to the unused select must leave every register unchanged.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
   typedef enum logic [1:0] {
      SEL_HI   = 2'd0,
      SEL_LO   = 2'd1,
      SEL_CTL  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   localparam logic [7:0] HI_RST  = 8'h00;
   localparam logic [7:0] LO_RST  = 8'h04;
   localparam logic [7:0] CTL_RST = 8'h00;

   localparam int CTL_WOR_BIT = 6;
   localparam int CTL_BUS_BIT = 5;
   localparam int CTL_PAR_BIT = 0;
   localparam logic [7:0] CTL_MASK = 8'h61;

   localparam int HI_TST_BIT = 7;
   localparam int HI_SMP_BIT = 6;
   localparam int HI_RSM_BIT = 5;
endpackage

// File: rtl/bclk_regs.sv
module bclk_regs
   import bclk_pkg::*;
#(
   parameter int RATE_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        sel,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic [RATE_W-1:0] rate_eff,
   output logic              commit,
   output logic [2:0]        hi_flags,
   output logic [7:0]        ctl_val
);
   localparam int HI_W = RATE_W - 8;
   localparam logic [7:0] HI_MASK = 8'hE0 | 8'((1 << HI_W) - 1);

   logic [7:0] hi_q, lo_q, stage_q, ctl_q;
   logic [RATE_W-1:0] rate_q, rate_nxt;

   assign commit   = wr_en && (sel == SEL_LO);
   assign rate_q   = {hi_q[HI_W-1:0], lo_q};
   assign rate_nxt = {stage_q[HI_W-1:0], wdata};
   assign rate_eff = commit ? rate_nxt : rate_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q    <= HI_RST;
         lo_q    <= LO_RST;
         stage_q <= HI_RST;
         ctl_q   <= CTL_RST;
      end else if (wr_en) begin
         case (sel)
            SEL_HI:  stage_q <= wdata & HI_MASK;
            SEL_LO: begin
               hi_q <= stage_q;
               lo_q <= wdata;
            end
            SEL_CTL: ctl_q <= wdata & CTL_MASK;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (sel)
         SEL_HI:  rdata = hi_q;
         SEL_LO:  rdata = lo_q;
         SEL_CTL: rdata = ctl_q;
         default: rdata = 8'h00;
      endcase
   end

   assign hi_flags = {hi_q[HI_TST_BIT], hi_q[HI_SMP_BIT], hi_q[HI_RSM_BIT]};
   assign ctl_val  = ctl_q;

   // R5
   stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_HI) |=> ($stable(rate_q) && $stable(hi_q)));

   // R9
   none_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_NONE) |=> ($stable(rate_q) && $stable(ctl_q) && $stable(stage_q)));
endmodule

// File: rtl/bclk_div.sv
module bclk_div #(
   parameter int PRESCALE = 32,
   parameter int RATE_W   = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate_eff,
   input  logic              load,
   input  logic              run_req,
   output logic              tick
);
   localparam longint MAX_SPAN = longint'(PRESCALE) * ((longint'(1) << RATE_W) - 1);
   localparam int     CNT_W    = $clog2(MAX_SPAN);
   localparam bit     P_POW2   = (PRESCALE & (PRESCALE - 1)) == 0;
   localparam int     SH       = $clog2(PRESCALE);

   logic [CNT_W-1:0] span, reload, cnt_q;
   logic active, active_q, restart;

   generate
      if (P_POW2) begin : g_shift
         assign span = CNT_W'(rate_eff) << SH;
      end else begin : g_mult
         assign span = CNT_W'(rate_eff) * CNT_W'(PRESCALE);
      end
   endgenerate

   assign reload  = span - 1'b1;
   assign active  = run_req && (rate_eff != '0);
   assign restart = active && (load || !active_q);
   assign tick    = active && !restart && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else begin
         active_q <= active;
         if (!active)          cnt_q <= '0;
         else if (restart)     cnt_q <= reload;
         else if (cnt_q == '0) cnt_q <= reload;
         else                  cnt_q <= cnt_q - 1'b1;
      end
   end

   // R3
   zero_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_eff == '0) |-> !tick);
endmodule

// File: rtl/bclk_rate_gen.sv
module bclk_rate_gen
   import bclk_pkg::*;
#(
   parameter int PRESCALE = 32,
   parameter int RATE_W   = 13
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [1:0] reg_sel,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_data,
   input  logic       rx_en,
   input  logic       tx_en,
   output logic       tick,
   output logic       wired_or_mode,
   output logic       bus_mode_en,
   output logic       parity_odd,
   output logic       test_mode,
   output logic       sample_mode,
   output logic       reset_mode
);
   generate
      if (PRESCALE < 2) begin : g_bad_prescale
         $error("PRESCALE must be at least 2");
      end
      if (RATE_W < 9 || RATE_W > 13) begin : g_bad_rate_w
         $error("RATE_W must lie in 9..13");
      end
   endgenerate

   logic [RATE_W-1:0] rate_eff;
   logic              commit;
   logic [2:0]        hi_flags;
   logic [7:0]        ctl_val;

   bclk_regs #(.RATE_W(RATE_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .sel      (reg_sel),
      .wdata    (wr_data),
      .rdata    (rd_data),
      .rate_eff (rate_eff),
      .commit   (commit),
      .hi_flags (hi_flags),
      .ctl_val  (ctl_val)
   );

   bclk_div #(.PRESCALE(PRESCALE), .RATE_W(RATE_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_eff (rate_eff),
      .load     (commit),
      .run_req  (rx_en | tx_en),
      .tick     (tick)
   );

   assign {test_mode, sample_mode, reset_mode} = hi_flags;
   assign wired_or_mode = ctl_val[CTL_WOR_BIT];
   assign bus_mode_en   = ctl_val[CTL_BUS_BIT];
   assign parity_odd    = ctl_val[CTL_PAR_BIT];

   // R4
   idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !tx_en) |-> !tick);

   // R2
   tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: tb/bclk_rate_gen_bench.sv
`timescale 1ns/1ps
module bclk_rate_gen_bench;
   localparam int P = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] reg_sel = 2'd0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic rx_en = 1'b0, tx_en = 1'b0;
   logic tick, wired_or_mode, bus_mode_en, parity_odd;
   logic test_mode, sample_mode, reset_mode;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   bclk_rate_gen #(.PRESCALE(P), .RATE_W(13)) u_bclk_rate_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
      .wr_data(wr_data), .rd_data(rd_data), .rx_en(rx_en), .tx_en(tx_en),
      .tick(tick), .wired_or_mode(wired_or_mode), .bus_mode_en(bus_mode_en),
      .parity_odd(parity_odd), .test_mode(test_mode),
      .sample_mode(sample_mode), .reset_mode(reset_mode)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; reg_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output int d);
      @(negedge clk);
      reg_sel = s;
      #1 d = int'(rd_data);
   endtask

   // first sample is the negedge right after the sampling edge
   task automatic latency(output int k);
      k = 1;
      while (!tick && k < 40000) begin
         @(negedge clk);
         k++;
      end
   endtask

   task automatic period(output int p, output int width);
      int guard = 0;
      while (!tick && guard < 40000) begin @(negedge clk); guard++; end
      @(negedge clk);
      width = tick ? 2 : 1;
      p = 1;
      while (!tick && p < 40000) begin @(negedge clk); p++; end
   endtask

   task automatic count_ticks(input int n, output int c);
      c = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (tick) c++;
      end
   endtask

   task automatic t_reset;
      int v;
      chk("R1 tick", int'(tick), 0);
      rd(2'd0, v); chk("R1 hi", v, 8'h00);
      rd(2'd1, v); chk("R1 lo", v, 8'h04);
      rd(2'd2, v); chk("R1 ctl", v, 8'h00);
      rd(2'd3, v); chk("R9 none read", v, 0);
      chk("R1 outputs", int'({wired_or_mode, bus_mode_en, parity_odd,
                              test_mode, sample_mode, reset_mode}), 0);
   endtask

   task automatic t_gating;
      int c, k, p, w;
      count_ticks(100, c); chk("R4 both off", c, 0);
      @(negedge clk); rx_en = 1'b1;
      @(negedge clk);
      latency(k); chk("R8 enable latency", k, P * 4);
      period(p, w); chk("R2 period D=4", p, P * 4); chk("R2 width", w, 1);
      @(negedge clk); tx_en = 1'b1;
      @(negedge clk); rx_en = 1'b0;
      period(p, w); chk("R4 tx alone", p, P * 4);
   endtask

   task automatic t_stage;
      int v, p, w, k;
      wr(2'd0, 8'h01);
      rd(2'd0, v); chk("R5 hi readback", v, 8'h00);
      period(p, w); chk("R5 period unchanged", p, P * 4);
      wr(2'd1, 8'h03);
      latency(k); chk("R8 commit latency", k, P * 259);
      period(p, w); chk("R6 period D=259", p, P * 259);
      rd(2'd0, v); chk("R6 hi live", v, 8'h01);
      rd(2'd1, v); chk("R6 lo live", v, 8'h03);
   endtask

   task automatic t_modes;
      int v, p, w;
      wr(2'd0, 8'hA0);
      chk("R5 mode flags held", int'({test_mode, sample_mode, reset_mode}), 0);
      wr(2'd1, 8'h05);
      chk("R6 mode flags", int'({test_mode, sample_mode, reset_mode}), 5);
      rd(2'd0, v); chk("R6 hi with flags", v, 8'hA0);
      period(p, w); chk("R2 period D=5", p, P * 5);
   endtask

   task automatic t_zero_and_max;
      int c, k;
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h00);
      count_ticks(300, c); chk("R3 zero rate", c, 0);
      wr(2'd1, 8'h01);
      latency(k); chk("R8 restart from zero", k, P * 1);
      wr(2'd0, 8'h1F);
      wr(2'd1, 8'hFF);
      latency(k); chk("R2 max divisor", k, P * 8191);
   endtask

   task automatic t_ctl;
      int v, h, l, cc;
      wr(2'd2, 8'hFF);
      rd(2'd2, v); chk("R7 ctl readback", v, 8'h61);
      chk("R7 ctl outputs", int'({wired_or_mode, bus_mode_en, parity_odd}), 7);
      wr(2'd2, 8'h20);
      chk("R7 bus only", int'({wired_or_mode, bus_mode_en, parity_odd}), 2);
      wr(2'd3, 8'hFF);
      rd(2'd0, h); rd(2'd1, l); rd(2'd2, cc);
      chk("R9 hi untouched", h, 8'h1F);
      chk("R9 lo untouched", l, 8'hFF);
      chk("R9 ctl untouched", cc, 8'h20);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_gating();
      t_stage();
      t_modes();
      t_zero_and_max();
      t_ctl();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule